// File: doc/BRIEF.md
# Memory Map Decoder with Access Trap

This block sits on a 32-bit processor bus and sorts every access into one of four classes: boot ROM, main RAM, the 256-byte control-register window, or invalid. An invalid access raises a one-cycle memory-exception trap. The block also holds the registers that shape the decode. A memory configuration word carries two size codes, one for RAM and one for ROM, and each code sets how much of its region answers. A control word carries the access-protection enable, and a waitstate word and two access-window words are passed out to the engines that use them.

Both decoded sizes start small after reset: 4 KB of ROM and 256 KB of RAM. Software must raise them before it touches higher addresses. Any word of the control window that has no function is plain scratch storage. It can be written and read back, it never traps, and it does not change the behaviour of the block. The memory arrays, the wait timing and the protection comparison live outside this block. It drives select lines, a trap flag, read data for the window and the register values.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset all select lines, the trap and read data are 0, and every window register reads 0. As a result, ROM decodes 4 KB and RAM decodes 256 KB.
- R2: ROM occupies addresses from 0x00000000. The size code in bits [6:4] of the configuration word (window offset 0x10) gives a ROM size of 4 KB << code, up to 512 KB. An address at or above that size, and below 0x00080000, raises the trap.
- R3: RAM occupies addresses from 0x02000000. The size code in bits [2:0] of the configuration word gives a RAM size of 256 KB << code, and codes 4 to 7 all give 4 MB. An address past the decoded size raises the trap.
- R4: Any address in 0x01F80000..0x01F800FF asserts the window select, for reads and for writes, and never traps.
- R5: Any address outside ROM, RAM and the window raises the trap. A trapped access returns read data 0.
- R6: Results appear one clock after an access with the valid strobe high. A cycle without the strobe gives all outputs 0 (selects, trap, read data) in the following cycle. Writes, and reads outside the window, return read data 0.
- R7: A write to a window word with no function stores the value, and a later read returns it. The write has no effect on decoding.
- R8: In the control word (offset 0x00) only bits 0, 1 and 3 are kept, and the other bits read 0. Bit 3 drives the protection-enable output.
- R9: Bits of the configuration word outside the two size codes are stored and read back, and they do not affect decoding.
- R10: The waitstate word (offset 0x18) and the access words (offsets 0x20 and 0x24) read back what was written and appear on their own outputs.
- R11: At most one of ROM select, RAM select, window select and trap is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Window read data, one cycle after the access |
| rom_sel_o | output | 1 | Access hit decoded ROM |
| ram_sel_o | output | 1 | Access hit decoded RAM |
| reg_sel_o | output | 1 | Access hit the control window |
| trap_o | output | 1 | Memory-exception pulse |
| prot_en_o | output | 1 | Access protection enabled |
| ctrl_o | output | 32 | Control word |
| mem_cfg_o | output | 32 | Memory configuration word |
| ws_cfg_o | output | 32 | Waitstate configuration word |
| acc0_o | output | 32 | Access word 0 |
| acc1_o | output | 32 | Access word 1 |

## Verification
The assertions assume that the bus holds the address and the write flag stable for the whole cycle in which the valid strobe is high, and that only aligned word addresses are presented. The strobe may be high in any cycle, including back-to-back accesses. The bench changes inputs only on the falling edge and uses word-aligned addresses throughout, including the boundary addresses just below and at each decoded limit. The protection property expects the control word to be written through its single aligned offset, and the stimulus writes it only there.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  localparam logic [31:0] ROM_BASE = 32'h0000_0000;
  localparam logic [31:0] RAM_BASE = 32'h0200_0000;
  localparam logic [23:0] WIN_TAG  = 24'h01F800;

  localparam int ROM_MIN_LG2 = 12;
  localparam int ROM_MAX_LG2 = 19;
  localparam int RAM_MIN_LG2 = 18;
  localparam int RAM_MAX_LG2 = 22;

  localparam int SZ_W       = 3;
  localparam int RAM_SZ_LSB = 0;
  localparam int ROM_SZ_LSB = 4;

  localparam int WIN_WORDS = 64;
  localparam int IDX_W     = $clog2(WIN_WORDS);

  localparam int IDX_CTRL = 'h00 >> 2;
  localparam int IDX_MCFG = 'h10 >> 2;
  localparam int IDX_WCFG = 'h18 >> 2;
  localparam int IDX_ACC0 = 'h20 >> 2;
  localparam int IDX_ACC1 = 'h24 >> 2;

  localparam logic [31:0] CTRL_MASK = 32'h0000_000B;
  localparam int PROT_BIT = 3;
endpackage

// File: rtl/mmd_region_dec.sv
module mmd_region_dec
  import mmd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   rom_sz_i,
  input  logic [SZ_W-1:0]   ram_sz_i,
  output logic              rom_hit_o,
  output logic              ram_hit_o,
  output logic              win_hit_o
);
  localparam int ROM_SPAN = ROM_MAX_LG2 - ROM_MIN_LG2;
  localparam int RAM_SPAN = RAM_MAX_LG2 - RAM_MIN_LG2;

  logic [5:0]        rom_lg, ram_lg;
  logic [ADDR_W-1:0] rom_off, ram_off;

  always_comb begin
    rom_lg = 6'(ROM_MIN_LG2) + ((int'(rom_sz_i) > ROM_SPAN) ? 6'(ROM_SPAN) : 6'(rom_sz_i));
    ram_lg = 6'(RAM_MIN_LG2) + ((int'(ram_sz_i) > RAM_SPAN) ? 6'(RAM_SPAN) : 6'(ram_sz_i));
    rom_off = addr_i - ROM_BASE;
    ram_off = addr_i - RAM_BASE;
    rom_hit_o = (addr_i >= ROM_BASE) && ((rom_off >> rom_lg) == '0);
    ram_hit_o = (addr_i >= RAM_BASE) && ((ram_off >> ram_lg) == '0);
    win_hit_o = (addr_i[ADDR_W-1:8] == WIN_TAG);
  end
endmodule

// File: rtl/mmd_reg_file.sv
module mmd_reg_file
  import mmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] mcfg_o,
  output logic [DATA_W-1:0] wcfg_o,
  output logic [DATA_W-1:0] acc0_o,
  output logic [DATA_W-1:0] acc1_o
);
  logic [DATA_W-1:0] word_q [WIN_WORDS];

  for (genvar g = 0; g < WIN_WORDS; g++) begin : g_word
    localparam logic [DATA_W-1:0] KEEP = (g == IDX_CTRL) ? DATA_W'(CTRL_MASK) : '1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q[g] <= '0;
      else if (wr_en_i && (idx_i == IDX_W'(g)))      word_q[g] <= wdata_i & KEEP;
    end
  end

  assign rd_word_o = word_q[idx_i];
  assign ctrl_o    = word_q[IDX_CTRL];
  assign mcfg_o    = word_q[IDX_MCFG];
  assign wcfg_o    = word_q[IDX_WCFG];
  assign acc0_o    = word_q[IDX_ACC0];
  assign acc1_o    = word_q[IDX_ACC1];
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              reg_sel_o,
  output logic              trap_o,
  output logic              prot_en_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] mem_cfg_o,
  output logic [DATA_W-1:0] ws_cfg_o,
  output logic [DATA_W-1:0] acc0_o,
  output logic [DATA_W-1:0] acc1_o
);
  logic              rom_hit, ram_hit, win_hit;
  logic [DATA_W-1:0] rd_word;

  mmd_region_dec u_dec (
    .addr_i    (addr_i),
    .rom_sz_i  (mem_cfg_o[ROM_SZ_LSB +: SZ_W]),
    .ram_sz_i  (mem_cfg_o[RAM_SZ_LSB +: SZ_W]),
    .rom_hit_o (rom_hit),
    .ram_hit_o (ram_hit),
    .win_hit_o (win_hit)
  );

  mmd_reg_file u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (req_i && we_i && win_hit),
    .idx_i     (addr_i[IDX_W+1:2]),
    .wdata_i   (wdata_i),
    .rd_word_o (rd_word),
    .ctrl_o    (ctrl_o),
    .mcfg_o    (mem_cfg_o),
    .wcfg_o    (ws_cfg_o),
    .acc0_o    (acc0_o),
    .acc1_o    (acc1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_sel_o <= 1'b0;
      ram_sel_o <= 1'b0;
      reg_sel_o <= 1'b0;
      trap_o    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      rom_sel_o <= req_i && rom_hit;
      ram_sel_o <= req_i && ram_hit;
      reg_sel_o <= req_i && win_hit;
      trap_o    <= req_i && !(rom_hit || ram_hit || win_hit);
      rdata_o   <= (req_i && win_hit && !we_i) ? rd_word : '0;
    end
  end

  assign prot_en_o = ctrl_o[PROT_BIT];
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker
  import mmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              prot_wbit_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rom_sel_o,
  input logic              ram_sel_o,
  input logic              reg_sel_o,
  input logic              trap_o,
  input logic              prot_en_o
);
  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o, reg_sel_o, trap_o}));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rom_sel_o && !ram_sel_o && !reg_sel_o && !trap_o && rdata_o == '0));

  p_window_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1:8] == WIN_TAG) |=> (reg_sel_o && !trap_o));

  p_far_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1:26] != '0) |=> (trap_o && rdata_o == '0));

  p_rom_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < 32'h0000_1000) |=> rom_sel_o);

  p_prot_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 32'h01F8_0000) |=> (prot_en_o == $past(prot_wbit_i)));
endmodule

bind mem_map_decoder mmd_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .prot_wbit_i (wdata_i[3]),
  .rdata_o     (rdata_o),
  .rom_sel_o   (rom_sel_o),
  .ram_sel_o   (ram_sel_o),
  .reg_sel_o   (reg_sel_o),
  .trap_o      (trap_o),
  .prot_en_o   (prot_en_o)
);

// File: tb/mem_map_decoder_bench.sv
module mem_map_decoder_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  exp;   // {trap, reg, ram, rom}
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    {1'b0, 32'h0000_0FFC, 32'h0, 4'b0001, 32'h0},          // R1 R2 4KB edge
    {1'b0, 32'h0000_1000, 32'h0, 4'b1000, 32'h0},          // R2 past 4KB
    {1'b0, 32'h0203_FFFC, 32'h0, 4'b0010, 32'h0},          // R3 256KB edge
    {1'b0, 32'h0204_0000, 32'h0, 4'b1000, 32'h0},          // R3 past 256KB
    {1'b0, 32'h01F8_0010, 32'h0, 4'b0100, 32'h0},          // R4 R1
    {1'b0, 32'h0010_0000, 32'h0, 4'b1000, 32'h0},          // R5 gap
    {1'b0, 32'h0240_0000, 32'h0, 4'b1000, 32'h0},          // R5 above RAM
    {1'b1, 32'h01F8_0010, 32'h74, 4'b0100, 32'h0},         // R2 R3 max sizes
    {1'b0, 32'h01F8_0010, 32'h0, 4'b0100, 32'h74},         // R9
    {1'b0, 32'h0007_FFFC, 32'h0, 4'b0001, 32'h0},          // R2 512KB
    {1'b0, 32'h0008_0000, 32'h0, 4'b1000, 32'h0},          // R5
    {1'b0, 32'h023F_FFFC, 32'h0, 4'b0010, 32'h0},          // R3 4MB
    {1'b0, 32'h0240_0000, 32'h0, 4'b1000, 32'h0},          // R5
    {1'b1, 32'h01F8_0010, 32'hFFFF_FF27, 4'b0100, 32'h0},  // R9 R3 clamp
    {1'b0, 32'h0000_3FFC, 32'h0, 4'b0001, 32'h0},          // R2 16KB
    {1'b0, 32'h0000_4000, 32'h0, 4'b1000, 32'h0},          // R2
    {1'b0, 32'h023F_FFFC, 32'h0, 4'b0010, 32'h0},          // R3 clamp 4MB
    {1'b0, 32'h01F8_0010, 32'h0, 4'b0100, 32'hFFFF_FF27},  // R9
    {1'b1, 32'h01F8_0000, 32'hFFFF_FFFF, 4'b0100, 32'h0},  // R8
    {1'b0, 32'h01F8_0000, 32'h0, 4'b0100, 32'h0000_000B},  // R8 mask
    {1'b1, 32'h01F8_00FC, 32'hDEAD_BEEF, 4'b0100, 32'h0},  // R7
    {1'b0, 32'h01F8_00FC, 32'h0, 4'b0100, 32'hDEAD_BEEF},  // R7
    {1'b0, 32'h0000_4000, 32'h0, 4'b1000, 32'h0},          // R7 no effect
    {1'b1, 32'h01F8_0018, 32'h1234_5678, 4'b0100, 32'h0},  // R10
    {1'b0, 32'h01F8_0018, 32'h0, 4'b0100, 32'h1234_5678},  // R10
    {1'b0, 32'hFFFF_FFFC, 32'h0, 4'b1000, 32'h0},          // R5
    {1'b1, 32'h0000_0010, 32'h5555_5555, 4'b0001, 32'h0},  // R6 write data 0
    {1'b1, 32'h01F8_0024, 32'hA5A5_0F0F, 4'b0100, 32'h0}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, ctrl_o, mem_cfg_o, ws_cfg_o, acc0_o, acc1_o;
  logic        rom_sel_o, ram_sel_o, reg_sel_o, trap_o, prot_en_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_map_decoder u_mem_map_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rom_sel_o(rom_sel_o), .ram_sel_o(ram_sel_o), .reg_sel_o(reg_sel_o),
    .trap_o(trap_o), .prot_en_o(prot_en_o), .ctrl_o(ctrl_o),
    .mem_cfg_o(mem_cfg_o), .ws_cfg_o(ws_cfg_o), .acc0_o(acc0_o), .acc1_o(acc1_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(logic we, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {trap_o, reg_sel_o, ram_sel_o, rom_sel_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 flags", 64'(flags()), 64'h0);
    check("R1 rdata", 64'(rdata_o), 64'h0);
    check("R1 mem_cfg", 64'(mem_cfg_o), 64'h0);
    check("R1 prot", 64'(prot_en_o), 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_i = 1'b1; we_i = VECS[i].we; addr_i = VECS[i].addr; wdata_i = VECS[i].wdata;
      @(posedge clk);
      #1;
      check($sformatf("R2-table vec%0d flags", i), 64'(flags()), 64'(VECS[i].exp));
      check($sformatf("R6 vec%0d rdata", i), 64'(rdata_o), 64'(VECS[i].rdata));
    end
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;

    // R6 idle cycle after a window read
    access(1'b0, 32'h01F8_0018, 32'h0);
    @(posedge clk); #1;
    check("R6 idle flags", 64'(flags()), 64'h0);
    check("R6 idle rdata", 64'(rdata_o), 64'h0);

    // R10 outputs
    check("R10 ws_cfg_o", 64'(ws_cfg_o), 64'h1234_5678);
    check("R10 acc1_o", 64'(acc1_o), 64'hA5A5_0F0F);
    access(1'b1, 32'h01F8_0020, 32'h0BAD_F00D);
    check("R10 acc0_o", 64'(acc0_o), 64'h0BAD_F00D);

    // R8 protection bit
    check("R8 prot on", 64'(prot_en_o), 64'h1);
    check("R8 ctrl_o", 64'(ctrl_o), 64'hB);
    access(1'b1, 32'h01F8_0000, 32'h0000_0007);
    check("R8 prot off", 64'(prot_en_o), 64'h0);
    check("R8 ctrl kept", 64'(ctrl_o), 64'h3);

    // R9 other config bits ignored: size codes unchanged, 16KB ROM
    access(1'b1, 32'h01F8_0010, 32'h8000_0827);
    access(1'b0, 32'h0000_3FFC, 32'h0);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 32'h0000_3FFC;
    @(posedge clk); #1;
    check("R9 rom edge", 64'(flags()), 64'b0001);
    @(negedge clk);
    addr_i = 32'h0000_4000;
    @(posedge clk); #1;
    check("R9 rom past", 64'(flags()), 64'b1000);
    @(negedge clk);
    req_i = 1'b0;

    // R1 reset restores small sizes
    rst_ni = 1'b0;
    #1;
    check("R1 reset mem_cfg", 64'(mem_cfg_o), 64'h0);
    check("R1 reset acc0", 64'(acc0_o), 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    req_i = 1'b1; addr_i = 32'h0000_1000;
    @(posedge clk); #1;
    check("R1 R2 post-reset rom", 64'(flags()), 64'b1000);
    @(negedge clk);
    addr_i = 32'h0204_0000;
    @(posedge clk); #1;
    check("R1 R3 post-reset ram", 64'(flags()), 64'b1000);
    @(negedge clk);
    addr_i = 32'h01F8_00FC;
    @(posedge clk); #1;
    check("R7 R1 scratch cleared", 64'(rdata_o), 64'h0);
    @(negedge clk);
    req_i = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule